// File: doc/BRIEF.md
# Banked General Register File

This block holds the integer and floating-point register state of a 32-bit RISC core. There are sixteen integer registers. Registers 0 to 7 exist twice, as two physical banks, and registers 8 to 15 are a single shared set. A status word decides which integer bank answers as registers 0 to 7. Bank 1 is used only when the privileged-mode bit (bit 30) and the bank bit (bit 29) are both set. The sixteen float-width registers also exist in two banks. Bit 21 of the float control word selects the active float bank. The pipeline uses two combinational integer read ports, one integer write port, one float read port and one float write port. Writes to the status word or the float control word change the active bank on the next clock edge. No data is copied when the bank changes.

The four condition flags live in their own flip-flops. They are written either by a status-word write or by a direct flag update. A status-word read merges them back into their bit positions: T is bit 0, S is bit 1, Q is bit 8 and M is bit 9. Inside each float bank the registers are kept word-swapped: register i is stored in slot i XOR 1. Both float read paths undo this swap.

A debug index port reaches the registers for a debugger. It sees the active view of the architectural list, and it can also reach either integer bank directly. Two small state machines track the bank selection:
- The integer machine has the states IB_BANK0 and IB_BANK1.
  - It moves from IB_BANK0 to IB_BANK1 on a status write that has both bits set.
  - It moves from IB_BANK1 to IB_BANK0 on a status write that has either bit clear.
  - In every other cycle it stays where it is.
- The float machine has the states FB_BANK0 and FB_BANK1.
  - It moves from FB_BANK0 to FB_BANK1 on a control write with bit 21 set.
  - It moves from FB_BANK1 to FB_BANK0 on a control write with bit 21 clear.
  - In every other cycle it stays where it is.

Top module: `bankreg_file`

## Requirements
- R1: After reset, the status word reads 0x700000F0, the float control word reads 0x00040001, every register reads 0, integer bank 1 is active and float bank 0 is active.
- R2: Integer bank 1 is active exactly when status bits 30 and 29 are both 1. Every other combination, including only one of the two bits set, selects bank 0.
- R3: Integer read indices 0 to 7 return the active bank and indices 8 to 15 return the shared set. A status write that changes the bank changes what indices 0 to 7 return from the next cycle on. The contents of both banks and of registers 8 to 15 are left unchanged.
- R4: An integer write to indices 0 to 7 in the same cycle as a bank-changing status write lands in the bank that was active before that write.
- R5: The float bank follows bit 21 of the control word. A write that toggles bit 21 swaps the sixteen float registers that the read paths see. A write that leaves bit 21 unchanged does not swap them. A float write in the same cycle as a toggling control write goes to the old bank.
- R6: The status word keeps only the bits in mask 0x700083F3 and reads all other bits as 0. The float control word keeps bits 21:0.
- R7: The flag update input is ordered {M, Q, S, T}, and a flag update changes status bits 9, 8, 1 and 0. A status write in the same cycle as a flag update wins, and the flags take the values of the status-write data.
- R8: Debug indices 0 to 15 return the active integer view. Index 22 returns the merged status word, index 24 the float control word, and indices 25 to 40 float registers 0 to 15 of the active float bank. Indices 16 to 21, 23, 41 and 42 are held outside this block: they raise the unsupported flag and return 0.
- R9: Debug indices 43 to 50 return bank 0 registers 0 to 7, and indices 51 to 58 return bank 1 registers 0 to 7, whichever bank is active.
- R10: Debug indices 59 to 127 raise the unsupported flag and return 0.
- R11: Float register i is stored in physical slot i XOR 1. The float read port and debug index 25+i both return the value last written to float register i of that bank.
- R12: Read ports and the debug port are combinational. A write becomes visible only after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rd_a_idx | input | 4 | Integer read port A index |
| rd_a_data | output | 32 | Integer read port A data |
| rd_b_idx | input | 4 | Integer read port B index |
| rd_b_data | output | 32 | Integer read port B data |
| wr_en | input | 1 | Integer write enable |
| wr_idx | input | 4 | Integer write index |
| wr_data | input | 32 | Integer write data |
| fp_rd_idx | input | 4 | Float read index |
| fp_rd_data | output | 32 | Float read data (active bank) |
| fp_wr_en | input | 1 | Float write enable |
| fp_wr_idx | input | 4 | Float write index |
| fp_wr_data | input | 32 | Float write data |
| flag_wr_en | input | 1 | Condition flag update enable |
| flag_wr_data | input | 4 | New flags {M, Q, S, T} |
| st_wr_en | input | 1 | Status word write enable |
| st_wr_data | input | 32 | Status word write data |
| st_rd_data | output | 32 | Status word with flags merged |
| fc_wr_en | input | 1 | Float control word write enable |
| fc_wr_data | input | 32 | Float control word write data |
| fc_rd_data | output | 32 | Float control word |
| dbg_idx | input | 7 | Debug register index |
| dbg_data | output | 32 | Debug read data |
| dbg_unsup | output | 1 | Debug index not served by this block |

## Verification
Two kinds of operation can land in the same cycle. The first is a pipeline register write together with a write that changes a bank: an integer write to index 0 to 7 with a bank-changing status write, or a float write with a control write that toggles bit 21. The second is a flag update together with a status write. The bench provokes each pairing on purpose in a directed step, and a random phase hits them again many times. Each outcome is judged at the ports: the debug bank indices show which physical bank took the data, and the status read shows which flag source won. A behavioural model applies the pre-edge bank rule and the status-over-flag priority, and it is compared against every output on every clock.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

    typedef enum logic {IB_BANK0 = 1'b0, IB_BANK1 = 1'b1} ibank_e;
    typedef enum logic {FB_BANK0 = 1'b0, FB_BANK1 = 1'b1} fbank_e;

    localparam int ST_W        = 32;
    localparam int ST_PRIV_BIT = 30;
    localparam int ST_BANK_BIT = 29;
    localparam int ST_T_BIT    = 0;
    localparam int ST_S_BIT    = 1;
    localparam int ST_Q_BIT    = 8;
    localparam int ST_M_BIT    = 9;

    localparam logic [ST_W-1:0] ST_KEEP  = 32'h7000_83F3;
    localparam logic [ST_W-1:0] ST_FLAGS = 32'h0000_0303;
    localparam logic [ST_W-1:0] ST_BODY  = ST_KEEP & ~ST_FLAGS;
    localparam logic [ST_W-1:0] ST_RESET = 32'h7000_00F0;

    localparam int              FC_SWAP_BIT = 21;
    localparam logic [ST_W-1:0] FC_KEEP     = 32'h003F_FFFF;
    localparam logic [ST_W-1:0] FC_RESET    = 32'h0004_0001;

    // debug index layout (a debugger decodes these positions)
    localparam int DBG_STATUS   = 22;
    localparam int DBG_FCTRL    = 24;
    localparam int DBG_FP_FIRST = 25;
    localparam int DBG_B0_FIRST = 43;

endpackage

// File: rtl/bank_ctrl.sv
module bank_ctrl
    import bankreg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            st_wr_en,
    input  logic [ST_W-1:0] st_wr_data,
    input  logic            flag_wr_en,
    input  logic [3:0]      flag_wr_data,
    input  logic            fc_wr_en,
    input  logic [ST_W-1:0] fc_wr_data,
    output logic [ST_W-1:0] st_rd_data,
    output logic [ST_W-1:0] fc_rd_data,
    output ibank_e          ibank,
    output fbank_e          fbank
);

    logic [ST_W-1:0] body_q;
    logic [ST_W-1:0] fc_q;
    logic            t_q, s_q, q_q, m_q;
    ibank_e          ib_state, ib_next;
    fbank_e          fb_state, fb_next;
    logic            req_hi;
    logic            req_fr;

    assign req_hi = st_wr_data[ST_PRIV_BIT] & st_wr_data[ST_BANK_BIT];
    assign req_fr = fc_wr_data[FC_SWAP_BIT];

    // next-state logic
    always_comb begin
        ib_next = ib_state;
        unique case (ib_state)
            IB_BANK0: if (st_wr_en && req_hi)  ib_next = IB_BANK1;
            IB_BANK1: if (st_wr_en && !req_hi) ib_next = IB_BANK0;
        endcase
        fb_next = fb_state;
        unique case (fb_state)
            FB_BANK0: if (fc_wr_en && req_fr)  fb_next = FB_BANK1;
            FB_BANK1: if (fc_wr_en && !req_fr) fb_next = FB_BANK0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ib_state <= IB_BANK1;
            fb_state <= FB_BANK0;
        end else begin
            ib_state <= ib_next;
            fb_state <= fb_next;
        end
    end

    // control word and flag storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            body_q <= ST_RESET & ST_BODY;
            fc_q   <= FC_RESET;
            t_q    <= ST_RESET[ST_T_BIT];
            s_q    <= ST_RESET[ST_S_BIT];
            q_q    <= ST_RESET[ST_Q_BIT];
            m_q    <= ST_RESET[ST_M_BIT];
        end else begin
            if (st_wr_en) begin
                body_q <= st_wr_data & ST_BODY;
                t_q    <= st_wr_data[ST_T_BIT];
                s_q    <= st_wr_data[ST_S_BIT];
                q_q    <= st_wr_data[ST_Q_BIT];
                m_q    <= st_wr_data[ST_M_BIT];
            end else if (flag_wr_en) begin
                {m_q, q_q, s_q, t_q} <= flag_wr_data;
            end
            if (fc_wr_en) fc_q <= fc_wr_data & FC_KEEP;
        end
    end

    // outputs
    always_comb begin
        st_rd_data           = body_q;
        st_rd_data[ST_T_BIT] = t_q;
        st_rd_data[ST_S_BIT] = s_q;
        st_rd_data[ST_Q_BIT] = q_q;
        st_rd_data[ST_M_BIT] = m_q;
        fc_rd_data           = fc_q;
        ibank                = ib_state;
        fbank                = fb_state;
    end

    // R2: bank state agrees with the stored status bits
    a_r2_state_tracks_status: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_state == IB_BANK1) == (body_q[ST_PRIV_BIT] && body_q[ST_BANK_BIT]));

    // R5: float bank state agrees with the stored swap bit
    a_r5_fbank_tracks_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_state == FB_BANK1) == fc_q[FC_SWAP_BIT]);

    // R6: no bits outside the keep masks
    a_r6_status_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_rd_data & ~ST_KEEP) == '0) && ((fc_rd_data & ~FC_KEEP) == '0));

    // R7: a status write overrides a same-cycle flag update
    a_r7_status_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr_en && flag_wr_en) |=>
            (st_rd_data[ST_T_BIT] == $past(st_wr_data[ST_T_BIT])) &&
            (st_rd_data[ST_M_BIT] == $past(st_wr_data[ST_M_BIT])));

endmodule

// File: rtl/gpr_array.sv
module gpr_array
    import bankreg_pkg::*;
#(
    parameter  int DATA_W     = 32,
    parameter  int NUM_GPR    = 16,
    parameter  int NUM_BANKED = 8,
    localparam int IDX_W      = $clog2(NUM_GPR),
    localparam int NUM_SHARED = NUM_GPR - NUM_BANKED,
    localparam int BIDX_W     = $clog2(NUM_BANKED),
    localparam int SIDX_W     = $clog2(NUM_SHARED)
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  ibank_e                                  ibank,
    input  logic                                    wr_en,
    input  logic [IDX_W-1:0]                        wr_idx,
    input  logic [DATA_W-1:0]                       wr_data,
    input  logic [IDX_W-1:0]                        rd_a_idx,
    output logic [DATA_W-1:0]                       rd_a_data,
    input  logic [IDX_W-1:0]                        rd_b_idx,
    output logic [DATA_W-1:0]                       rd_b_data,
    output logic [1:0][NUM_BANKED-1:0][DATA_W-1:0]  banked_q,
    output logic [NUM_SHARED-1:0][DATA_W-1:0]       shared_q
);

    for (genvar b = 0; b < 2; b++) begin : g_bank
        for (genvar r = 0; r < NUM_BANKED; r++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    banked_q[b][r] <= '0;
                else if (wr_en && wr_idx == IDX_W'(r) && logic'(ibank) == 1'(b))
                    banked_q[b][r] <= wr_data;
            end
        end
    end

    for (genvar s = 0; s < NUM_SHARED; s++) begin : g_shared
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                shared_q[s] <= '0;
            else if (wr_en && wr_idx == IDX_W'(NUM_BANKED + s))
                shared_q[s] <= wr_data;
        end
    end

    function automatic logic [DATA_W-1:0] view(input logic [IDX_W-1:0] idx);
        if (idx < IDX_W'(NUM_BANKED))
            return banked_q[ibank][BIDX_W'(idx)];
        else
            return shared_q[SIDX_W'(idx - IDX_W'(NUM_BANKED))];
    endfunction

    assign rd_a_data = view(rd_a_idx);
    assign rd_b_data = view(rd_b_idx);

    // R4: a banked write goes to the bank active before the edge
    a_r4_write_lands_old_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx < IDX_W'(NUM_BANKED)) |=>
            banked_q[$past(ibank)][BIDX_W'($past(wr_idx))] == $past(wr_data));

    // R3: without a write, a bank change moves no data
    a_r3_swap_moves_nothing: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(banked_q) && $stable(shared_q)));

endmodule

// File: rtl/fpr_array.sv
module fpr_array
    import bankreg_pkg::*;
#(
    parameter  int DATA_W  = 32,
    parameter  int NUM_FPR = 16,
    localparam int FIDX_W  = $clog2(NUM_FPR)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  fbank_e                               fbank,
    input  logic                                 wr_en,
    input  logic [FIDX_W-1:0]                    wr_idx,
    input  logic [DATA_W-1:0]                    wr_data,
    input  logic [FIDX_W-1:0]                    rd_idx,
    output logic [DATA_W-1:0]                    rd_data,
    output logic [1:0][NUM_FPR-1:0][DATA_W-1:0]  slots_q
);

    logic [FIDX_W-1:0] wr_slot;
    assign wr_slot = wr_idx ^ FIDX_W'(1);

    for (genvar b = 0; b < 2; b++) begin : g_bank
        for (genvar s = 0; s < NUM_FPR; s++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    slots_q[b][s] <= '0;
                else if (wr_en && wr_slot == FIDX_W'(s) && logic'(fbank) == 1'(b))
                    slots_q[b][s] <= wr_data;
            end
        end
    end

    assign rd_data = slots_q[fbank][rd_idx ^ FIDX_W'(1)];

    // R11: register i is held in slot i xor 1 of the pre-edge bank (R5)
    a_r11_slot_swapped: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> slots_q[$past(fbank)][$past(wr_idx) ^ FIDX_W'(1)] == $past(wr_data));

endmodule

// File: rtl/dbg_view.sv
module dbg_view
    import bankreg_pkg::*;
#(
    parameter  int DATA_W     = 32,
    parameter  int NUM_GPR    = 16,
    parameter  int NUM_BANKED = 8,
    parameter  int NUM_FPR    = 16,
    parameter  int DBG_W      = 7,
    localparam int IDX_W      = $clog2(NUM_GPR),
    localparam int NUM_SHARED = NUM_GPR - NUM_BANKED,
    localparam int BIDX_W     = $clog2(NUM_BANKED),
    localparam int SIDX_W     = $clog2(NUM_SHARED),
    localparam int FIDX_W     = $clog2(NUM_FPR),
    localparam int FP_END     = DBG_FP_FIRST + NUM_FPR,
    localparam int B1_FIRST   = DBG_B0_FIRST + NUM_BANKED,
    localparam int B1_END     = B1_FIRST + NUM_BANKED
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [DBG_W-1:0]                        dbg_idx,
    input  ibank_e                                  ibank,
    input  fbank_e                                  fbank,
    input  logic [1:0][NUM_BANKED-1:0][DATA_W-1:0]  banked_q,
    input  logic [NUM_SHARED-1:0][DATA_W-1:0]       shared_q,
    input  logic [1:0][NUM_FPR-1:0][DATA_W-1:0]     slots_q,
    input  logic [ST_W-1:0]                         st_rd_data,
    input  logic [ST_W-1:0]                         fc_rd_data,
    output logic [DATA_W-1:0]                       dbg_data,
    output logic                                    dbg_unsup
);

    logic [IDX_W-1:0] gidx;

    always_comb begin
        dbg_data  = '0;
        dbg_unsup = 1'b0;
        gidx      = IDX_W'(dbg_idx);
        if (dbg_idx < DBG_W'(NUM_GPR)) begin
            if (gidx < IDX_W'(NUM_BANKED))
                dbg_data = banked_q[ibank][BIDX_W'(gidx)];
            else
                dbg_data = shared_q[SIDX_W'(gidx - IDX_W'(NUM_BANKED))];
        end else if (dbg_idx == DBG_W'(DBG_STATUS)) begin
            dbg_data = DATA_W'(st_rd_data);
        end else if (dbg_idx == DBG_W'(DBG_FCTRL)) begin
            dbg_data = DATA_W'(fc_rd_data);
        end else if (dbg_idx >= DBG_W'(DBG_FP_FIRST) && dbg_idx < DBG_W'(FP_END)) begin
            dbg_data = slots_q[fbank][FIDX_W'(dbg_idx - DBG_W'(DBG_FP_FIRST)) ^ FIDX_W'(1)];
        end else if (dbg_idx >= DBG_W'(DBG_B0_FIRST) && dbg_idx < DBG_W'(B1_FIRST)) begin
            dbg_data = banked_q[0][BIDX_W'(dbg_idx - DBG_W'(DBG_B0_FIRST))];
        end else if (dbg_idx >= DBG_W'(B1_FIRST) && dbg_idx < DBG_W'(B1_END)) begin
            dbg_data = banked_q[1][BIDX_W'(dbg_idx - DBG_W'(B1_FIRST))];
        end else begin
            dbg_unsup = 1'b1;
        end
    end

    // R8: an unsupported index always returns zero
    a_r8_unsup_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_unsup |-> (dbg_data == '0));

    // R10: everything past the bank-1 range is unsupported
    a_r10_above_range_unsupported: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_idx >= DBG_W'(B1_END)) |-> dbg_unsup);

endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
    import bankreg_pkg::*;
#(
    parameter  int DATA_W     = 32,
    parameter  int NUM_GPR    = 16,
    parameter  int NUM_BANKED = 8,
    parameter  int NUM_FPR    = 16,
    parameter  int DBG_W      = 7,
    localparam int IDX_W      = $clog2(NUM_GPR),
    localparam int FIDX_W     = $clog2(NUM_FPR),
    localparam int NUM_SHARED = NUM_GPR - NUM_BANKED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [FIDX_W-1:0] fp_rd_idx,
    output logic [DATA_W-1:0] fp_rd_data,
    input  logic              fp_wr_en,
    input  logic [FIDX_W-1:0] fp_wr_idx,
    input  logic [DATA_W-1:0] fp_wr_data,
    input  logic              flag_wr_en,
    input  logic [3:0]        flag_wr_data,
    input  logic              st_wr_en,
    input  logic [ST_W-1:0]   st_wr_data,
    output logic [ST_W-1:0]   st_rd_data,
    input  logic              fc_wr_en,
    input  logic [ST_W-1:0]   fc_wr_data,
    output logic [ST_W-1:0]   fc_rd_data,
    input  logic [DBG_W-1:0]  dbg_idx,
    output logic [DATA_W-1:0] dbg_data,
    output logic              dbg_unsup
);

    ibank_e                                  ibank;
    fbank_e                                  fbank;
    logic [1:0][NUM_BANKED-1:0][DATA_W-1:0]  banked_q;
    logic [NUM_SHARED-1:0][DATA_W-1:0]       shared_q;
    logic [1:0][NUM_FPR-1:0][DATA_W-1:0]     slots_q;

    bank_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .st_wr_en     (st_wr_en),
        .st_wr_data   (st_wr_data),
        .flag_wr_en   (flag_wr_en),
        .flag_wr_data (flag_wr_data),
        .fc_wr_en     (fc_wr_en),
        .fc_wr_data   (fc_wr_data),
        .st_rd_data   (st_rd_data),
        .fc_rd_data   (fc_rd_data),
        .ibank        (ibank),
        .fbank        (fbank)
    );

    gpr_array #(
        .DATA_W     (DATA_W),
        .NUM_GPR    (NUM_GPR),
        .NUM_BANKED (NUM_BANKED)
    ) u_gpr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ibank     (ibank),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_a_idx  (rd_a_idx),
        .rd_a_data (rd_a_data),
        .rd_b_idx  (rd_b_idx),
        .rd_b_data (rd_b_data),
        .banked_q  (banked_q),
        .shared_q  (shared_q)
    );

    fpr_array #(
        .DATA_W  (DATA_W),
        .NUM_FPR (NUM_FPR)
    ) u_fpr (
        .clk     (clk),
        .rst_n   (rst_n),
        .fbank   (fbank),
        .wr_en   (fp_wr_en),
        .wr_idx  (fp_wr_idx),
        .wr_data (fp_wr_data),
        .rd_idx  (fp_rd_idx),
        .rd_data (fp_rd_data),
        .slots_q (slots_q)
    );

    dbg_view #(
        .DATA_W     (DATA_W),
        .NUM_GPR    (NUM_GPR),
        .NUM_BANKED (NUM_BANKED),
        .NUM_FPR    (NUM_FPR),
        .DBG_W      (DBG_W)
    ) u_dbg (
        .clk        (clk),
        .rst_n      (rst_n),
        .dbg_idx    (dbg_idx),
        .ibank      (ibank),
        .fbank      (fbank),
        .banked_q   (banked_q),
        .shared_q   (shared_q),
        .slots_q    (slots_q),
        .st_rd_data (st_rd_data),
        .fc_rd_data (fc_rd_data),
        .dbg_data   (dbg_data),
        .dbg_unsup  (dbg_unsup)
    );

endmodule

// File: tb/tb_bankreg_file.sv
module tb_bankreg_file;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_idx, rd_b_idx, wr_idx, fp_rd_idx, fp_wr_idx, flag_wr_data;
    logic [31:0] rd_a_data, rd_b_data, wr_data, fp_rd_data, fp_wr_data;
    logic [31:0] st_wr_data, st_rd_data, fc_wr_data, fc_rd_data, dbg_data;
    logic        wr_en, fp_wr_en, flag_wr_en, st_wr_en, fc_wr_en, dbg_unsup;
    logic [6:0]  dbg_idx;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bankreg_file dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .fp_rd_idx(fp_rd_idx), .fp_rd_data(fp_rd_data),
        .fp_wr_en(fp_wr_en), .fp_wr_idx(fp_wr_idx), .fp_wr_data(fp_wr_data),
        .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
        .st_wr_en(st_wr_en), .st_wr_data(st_wr_data), .st_rd_data(st_rd_data),
        .fc_wr_en(fc_wr_en), .fc_wr_data(fc_wr_data), .fc_rd_data(fc_rd_data),
        .dbg_idx(dbg_idx), .dbg_data(dbg_data), .dbg_unsup(dbg_unsup)
    );

    // behavioural reference state
    logic [31:0] m_gpr [0:1][0:7];
    logic [31:0] m_shr [0:7];
    logic [31:0] m_fp  [0:1][0:15];
    logic [31:0] m_st, m_fc;
    logic        m_t, m_s, m_q, m_m;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic m_ib();
        return m_st[30] & m_st[29];
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] i);
        if (i < 8) return m_gpr[m_ib()][i[2:0]];
        return m_shr[i[2:0]];
    endfunction

    function automatic logic [31:0] m_status();
        return m_st | {22'd0, m_m, m_q, 6'd0, m_s, m_t};
    endfunction

    function automatic logic [32:0] m_dbg(input int i);
        if (i < 16)                 return {1'b0, m_read(4'(i))};
        if (i == 22)                return {1'b0, m_status()};
        if (i == 24)                return {1'b0, m_fc};
        if (i >= 25 && i <= 40)     return {1'b0, m_fp[m_fc[21]][i-25]};
        if (i >= 43 && i <= 50)     return {1'b0, m_gpr[0][i-43]};
        if (i >= 51 && i <= 58)     return {1'b0, m_gpr[1][i-51]};
        return {1'b1, 32'd0};
    endfunction

    task automatic model_reset();
        for (int b = 0; b < 2; b++) begin
            for (int r = 0; r < 8; r++) m_gpr[b][r] = '0;
            for (int r = 0; r < 16; r++) m_fp[b][r] = '0;
        end
        for (int r = 0; r < 8; r++) m_shr[r] = '0;
        m_st = 32'h7000_00F0; m_fc = 32'h0004_0001;
        {m_m, m_q, m_s, m_t} = 4'b0000;
    endtask

    task automatic model_step();
        logic ib, fb;
        ib = m_ib();
        fb = m_fc[21];
        if (wr_en) begin
            if (wr_idx < 8) m_gpr[ib][wr_idx[2:0]] = wr_data;
            else            m_shr[wr_idx[2:0]] = wr_data;
        end
        if (fp_wr_en) m_fp[fb][fp_wr_idx] = fp_wr_data;
        if (st_wr_en) begin
            m_st = st_wr_data & 32'h7000_80F0;
            m_t = st_wr_data[0]; m_s = st_wr_data[1];
            m_q = st_wr_data[8]; m_m = st_wr_data[9];
        end else if (flag_wr_en) begin
            {m_m, m_q, m_s, m_t} = flag_wr_data;
        end
        if (fc_wr_en) m_fc = fc_wr_data & 32'h003F_FFFF;
    endtask

    task automatic compare();
        logic [32:0] d;
        d = m_dbg(int'(dbg_idx));
        check("R3 read port A", rd_a_data, m_read(rd_a_idx));
        check("R3 read port B", rd_b_data, m_read(rd_b_idx));
        check("R11 float read", fp_rd_data, m_fp[m_fc[21]][fp_rd_idx]);
        check("R7 status read", st_rd_data, m_status());
        check("R6 control read", fc_rd_data, m_fc);
        check("R8 debug data", dbg_data, d[31:0]);
        check("R10 debug unsupported", {31'd0, dbg_unsup}, {31'd0, d[32]});
    endtask

    // inputs are set after a negedge; cyc compares, then clocks
    task automatic cyc();
        #2 compare();
        @(posedge clk);
        #1 model_step();
        @(negedge clk);
        wr_en = 0; fp_wr_en = 0; flag_wr_en = 0; st_wr_en = 0; fc_wr_en = 0;
    endtask

    task automatic look();
        #1;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rd_a_idx = 0; rd_b_idx = 0; wr_idx = 0; fp_rd_idx = 0; fp_wr_idx = 0;
        flag_wr_data = 0; wr_data = 0; fp_wr_data = 0; st_wr_data = 0; fc_wr_data = 0;
        wr_en = 0; fp_wr_en = 0; flag_wr_en = 0; st_wr_en = 0; fc_wr_en = 0; dbg_idx = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_a_idx = 5; dbg_idx = 51; look();
        check("R1 status reset", st_rd_data, 32'h7000_00F0);
        check("R1 control reset", fc_rd_data, 32'h0004_0001);
        check("R1 register reset", rd_a_data, 32'h0);
        check("R1 bank1 reg0 reset", dbg_data, 32'h0);
        cyc();

        // bank 1 active after reset: write r0, r9
        wr_en = 1; wr_idx = 0; wr_data = 32'h11; cyc();
        wr_en = 1; wr_idx = 9; wr_data = 32'h99; cyc();
        // R4 bank-changing status write with banked write in the same cycle
        st_wr_en = 1; st_wr_data = 32'h4000_0000;
        wr_en = 1; wr_idx = 1; wr_data = 32'h22; cyc();
        rd_a_idx = 0; rd_b_idx = 9; dbg_idx = 51; look();
        check("R2 privileged only selects bank0", rd_a_data, 32'h0);
        check("R3 shared reg survives swap", rd_b_data, 32'h99);
        check("R9 bank1 reg0 direct", dbg_data, 32'h11);
        dbg_idx = 52; look();
        check("R4 write went to old bank", dbg_data, 32'h22);
        dbg_idx = 1; look();
        check("R8 debug active view", dbg_data, 32'h0);
        cyc();

        wr_en = 1; wr_idx = 0; wr_data = 32'h33; cyc();
        st_wr_en = 1; st_wr_data = 32'h2000_0000; cyc();
        rd_a_idx = 0; look();
        check("R2 bank bit only selects bank0", rd_a_data, 32'h33);
        cyc();
        st_wr_en = 1; st_wr_data = 32'h6000_0000; cyc();
        dbg_idx = 43; look();
        check("R3 swap back to bank1", rd_a_data, 32'h11);
        check("R9 bank0 reg0 direct", dbg_data, 32'h33);
        cyc();

        st_wr_en = 1; st_wr_data = 32'hFFFF_FFFF; cyc();
        look(); check("R6 status mask", st_rd_data, 32'h7000_83F3);
        flag_wr_en = 1; flag_wr_data = 4'b0000; cyc();
        look(); check("R7 flag update clears flags", st_rd_data, 32'h7000_80F0);
        st_wr_en = 1; st_wr_data = 32'h0000_0001;
        flag_wr_en = 1; flag_wr_data = 4'b1111; cyc();
        look(); check("R7 status write beats flag update", st_rd_data, 32'h0000_0001);

        // float banks
        fp_wr_en = 1; fp_wr_idx = 3; fp_wr_data = 32'hF3; cyc();
        fp_wr_en = 1; fp_wr_idx = 2; fp_wr_data = 32'hF2; cyc();
        fp_rd_idx = 3; dbg_idx = 27; look();
        check("R11 float reg3", fp_rd_data, 32'hF3);
        check("R11 debug float reg2", dbg_data, 32'hF2);
        cyc();
        fc_wr_en = 1; fc_wr_data = 32'h0020_0000;
        fp_wr_en = 1; fp_wr_idx = 4; fp_wr_data = 32'h44; cyc();
        fp_rd_idx = 3; look();
        check("R5 toggle swaps float bank", fp_rd_data, 32'h0);
        cyc();
        fp_wr_en = 1; fp_wr_idx = 3; fp_wr_data = 32'hB3; cyc();
        fc_wr_en = 1; fc_wr_data = 32'h0020_0001; cyc();
        look(); check("R5 unchanged bit keeps bank", fp_rd_data, 32'hB3);
        fc_wr_en = 1; fc_wr_data = 32'h0; cyc();
        look(); check("R5 toggle back", fp_rd_data, 32'hF3);
        fp_rd_idx = 4; look();
        check("R5 same-cycle float write hit old bank", fp_rd_data, 32'h44);
        cyc();
        fc_wr_en = 1; fc_wr_data = 32'hFFFF_FFFF; cyc();
        dbg_idx = 24; look();
        check("R6 control mask", fc_rd_data, 32'h003F_FFFF);
        check("R8 debug control", dbg_data, 32'h003F_FFFF);
        dbg_idx = 22; look();
        check("R8 debug status", dbg_data, 32'h0000_0001);
        dbg_idx = 16; look();
        check("R8 outside-held index unsupported", {31'd0, dbg_unsup}, 32'd1);
        cyc();
        dbg_idx = 59; look();
        check("R10 index 59 unsupported", {31'd0, dbg_unsup}, 32'd1);
        dbg_idx = 93; look();
        check("R10 index 93 unsupported", {31'd0, dbg_unsup}, 32'd1);
        dbg_idx = 127; look();
        check("R10 index 127 data zero", dbg_data, 32'h0);
        cyc();

        // R12 combinational read shows old value until the edge
        wr_en = 1; wr_idx = 10; wr_data = 32'h5A; rd_a_idx = 10; look();
        check("R12 no same-cycle bypass", rd_a_data, 32'h0);
        cyc();
        look(); check("R12 visible after edge", rd_a_data, 32'h5A);

        // debug sweep against the model
        for (int i = 0; i < 128; i++) begin
            dbg_idx = 7'(i);
            cyc();
        end

        // random phase: same-cycle pairings occur often
        for (int n = 0; n < 600; n++) begin
            rd_a_idx = 4'($urandom); rd_b_idx = 4'($urandom);
            fp_rd_idx = 4'($urandom); dbg_idx = 7'($urandom_range(0, 63));
            wr_en = 1'($urandom); wr_idx = 4'($urandom); wr_data = $urandom;
            fp_wr_en = 1'($urandom); fp_wr_idx = 4'($urandom); fp_wr_data = $urandom;
            flag_wr_en = ($urandom_range(0, 3) == 0); flag_wr_data = 4'($urandom);
            st_wr_en = ($urandom_range(0, 5) == 0); st_wr_data = $urandom;
            fc_wr_en = ($urandom_range(0, 5) == 0); fc_wr_data = $urandom;
            cyc();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule